// File: doc/BRIEF.md
# Masked Readback Verify Engine

This block checks an FPGA's configuration memory after it has been read back. Three byte streams come in, each with its own valid/ready pair: the readback bytes from the configuration port, the expected image and a mask image, both fetched from flash. A readback bit passes when the expected bit equals the mask bit ANDed with the readback bit. A byte that holds any failing bit is an erroneous byte. Each erroneous byte raises a one-cycle scrub request straight away and adds one to a 4-bit error count. The count stops at 15 and does not wrap.

A run begins with a start pulse, which also gives the run length in bytes. The engine takes one byte from all three streams together, on a cycle when all three are valid. A mismatch does not stop the run: every byte up to the programmed length is still compared. When the last byte has been taken, `done` goes high and stays high until the next start. The image sizes this block is built for are about 368 KB, so the length field has 20 bits.

The controller has three states. `ST_IDLE` is the state after reset. `ST_RUN` compares bytes. `ST_DONE` holds the result. Its transitions are:
- IDLE→RUN on start with a non-zero length.
- IDLE→DONE on start with a zero length.
- RUN→DONE when the last byte is taken.
- DONE→RUN and DONE→DONE on a new start, chosen by the length in the same way.
- Every other case stays in the same state.

Top module: `rbv_engine`

## Requirements
- R1: After reset, `done` and `scrub_req` are 0, `err_count` is 0 and all three ready outputs are 0.
- R2: A readback bit passes when exp_data[i] == (msk_data[i] & rb_data[i]). A byte is erroneous when any of its 8 bits fails. Bits whose mask bit is 0 pass only when the expected bit is 0.
- R3: All three ready outputs are high together, and only in ST_RUN on a cycle when rb_valid, exp_valid and msk_valid are all 1. All three streams are consumed in that same cycle. While any stream is not valid, no byte is consumed.
- R4: `scrub_req` is 1 for exactly the cycle after an erroneous byte is consumed, and 0 in every other cycle.
- R5: `err_count` goes up by one for each erroneous byte consumed. Once it reaches 15 it stays at 15.
- R6: A start pulse in ST_IDLE or ST_DONE clears `err_count` and the byte count and samples `run_len`. A start pulse in ST_RUN has no effect.
- R7: `done` goes high in the cycle after the run_len-th byte is consumed. It stays high until the next start. Erroneous bytes do not end the run early.
- R8: A start with `run_len` equal to 0 moves straight to ST_DONE. No byte is consumed in that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a verify run |
| run_len | input | 20 | Number of bytes to compare, sampled on start |
| rb_valid | input | 1 | Readback byte valid |
| rb_data | input | 8 | Readback byte |
| rb_ready | output | 1 | Readback byte taken |
| exp_valid | input | 1 | Expected byte valid |
| exp_data | input | 8 | Expected byte |
| exp_ready | output | 1 | Expected byte taken |
| msk_valid | input | 1 | Mask byte valid |
| msk_data | input | 8 | Mask byte |
| msk_ready | output | 1 | Mask byte taken |
| scrub_req | output | 1 | One-cycle scrub request after an erroneous byte |
| err_count | output | 4 | Saturating count of erroneous bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |

## Verification
The hardest states to reach from the ports are these:
- the error count sitting at its ceiling while erroneous bytes keep arriving;
- a start pulse landing in the middle of a run.

To reach the ceiling, the stimulus programs a 20-byte run in which every byte fails. Each of the last five bytes must still raise a scrub request while the count stays at 15.

To test the mid-run start, a pulse is issued after one erroneous byte. The kept count shows that the pulse was ignored. The byte on which `done` rises shows that the original length was kept.

A stall is made by withholding a single stream's valid. During the stall the readies must stay low and the run must not finish early.

// File: rtl/rbv_pkg.sv
package rbv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rbv_state_e;
endpackage

// File: rtl/rbv_compare.sv
// Per-bit masked comparison of one byte triple.
module rbv_compare #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rb_byte,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic [DATA_W-1:0] msk_byte,
    output logic [DATA_W-1:0] bad_bits,
    output logic              mismatch
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // A bit fails when the expected bit differs from mask AND readback.
        assign bad_bits[i] = exp_byte[i] ^ (msk_byte[i] & rb_byte[i]);
    end

    assign mismatch = |bad_bits;
endmodule

// File: rtl/rbv_sat_counter.sv
// Error counter that stops at its maximum value.
module rbv_sat_counter #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [ERR_W-1:0] cnt_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    logic [ERR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX)); // R5
    AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/rbv_byte_counter.sv
// Counts consumed bytes against the length sampled at load time.
module rbv_byte_counter #(
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_i,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            count_q <= '0;
        end else if (load) begin
            len_q   <= len_i;
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last = (count_q == len_q - 1'b1);

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count_q < len_q)); // R7
endmodule

// File: rtl/rbv_engine.sv
// Masked readback verify engine: top level with the run controller.
module rbv_engine
    import rbv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 20,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  run_len,
    input  logic              rb_valid,
    input  logic [DATA_W-1:0] rb_data,
    output logic              rb_ready,
    input  logic              exp_valid,
    input  logic [DATA_W-1:0] exp_data,
    output logic              exp_ready,
    input  logic              msk_valid,
    input  logic [DATA_W-1:0] msk_data,
    output logic              msk_ready,
    output logic              scrub_req,
    output logic [ERR_W-1:0]  err_count,
    output logic              busy,
    output logic              done
);
    rbv_state_e        state_q, state_d;
    logic              all_valid;
    logic              accept;
    logic              start_evt;
    logic              len_zero;
    logic              last_byte;
    logic              mismatch;
    logic [DATA_W-1:0] bad_bits;
    logic              scrub_q;

    assign all_valid = rb_valid & exp_valid & msk_valid;
    assign len_zero  = (run_len == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = len_zero ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (accept && last_byte) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (start) state_d = len_zero ? ST_DONE : ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        accept    = 1'b0;
        start_evt = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: start_evt = start;
            ST_RUN: begin
                busy   = 1'b1;
                accept = all_valid;
            end
            ST_DONE: begin
                done      = 1'b1;
                start_evt = start;
            end
            default: ;
        endcase
    end

    assign rb_ready  = accept;
    assign exp_ready = accept;
    assign msk_ready = accept;

    rbv_compare #(.DATA_W(DATA_W)) u_cmp (
        .rb_byte  (rb_data),
        .exp_byte (exp_data),
        .msk_byte (msk_data),
        .bad_bits (bad_bits),
        .mismatch (mismatch)
    );

    rbv_byte_counter #(.LEN_W(LEN_W)) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_evt),
        .len_i (run_len),
        .step  (accept),
        .last  (last_byte)
    );

    rbv_sat_counter #(.ERR_W(ERR_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_evt),
        .inc   (accept & mismatch),
        .cnt_o (err_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scrub_q <= 1'b0;
        end else begin
            scrub_q <= accept & mismatch;
        end
    end

    assign scrub_req = scrub_q;

    AST_READY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        rb_ready |-> (rb_valid && exp_valid && msk_valid && busy)); // R3
    AST_SCRUB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req |-> $past(rb_ready && mismatch)); // R4
    AST_DONE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(rb_ready || exp_ready || msk_ready)); // R7
    AST_START_IGNORED_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !rb_ready) |=> $stable(err_count)); // R6
endmodule

// File: tb/rbv_engine_test.sv
module rbv_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] run_len = '0;
    logic        rb_valid = 1'b0, exp_valid = 1'b0, msk_valid = 1'b0;
    logic [7:0]  rb_data = '0, exp_data = '0, msk_data = '0;
    logic        rb_ready, exp_ready, msk_ready;
    logic        scrub_req, busy, done;
    logic [3:0]  err_count;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rbv_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
        .rb_valid(rb_valid), .rb_data(rb_data), .rb_ready(rb_ready),
        .exp_valid(exp_valid), .exp_data(exp_data), .exp_ready(exp_ready),
        .msk_valid(msk_valid), .msk_data(msk_data), .msk_ready(msk_ready),
        .scrub_req(scrub_req), .err_count(err_count), .busy(busy), .done(done)
    );

    // {rb, exp, msk, byte_is_bad}
    localparam int NVEC = 8;
    localparam logic [24:0] VEC [NVEC] = '{
        {8'hA5, 8'hA5, 8'hFF, 1'b0},
        {8'hA5, 8'hA4, 8'hFF, 1'b1},
        {8'hFF, 8'h0F, 8'h0F, 1'b0},
        {8'h00, 8'h00, 8'h00, 1'b0},
        {8'hFF, 8'h01, 8'h00, 1'b1},
        {8'h3C, 8'h30, 8'hF0, 1'b0},
        {8'h80, 8'h00, 8'h80, 1'b1},
        {8'h5A, 8'h5A, 8'h5A, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Called at a negedge; returns at the negedge after start was sampled.
    task automatic pulse_start(input int len);
        run_len = 20'(len);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called at a negedge; offers one byte triple and returns at the next negedge.
    task automatic feed(input logic [7:0] r, input logic [7:0] e, input logic [7:0] m);
        rb_data = r; exp_data = e; msk_data = m;
        rb_valid = 1'b1; exp_valid = 1'b1; msk_valid = 1'b1;
        #1;
        chk(rb_ready && exp_ready && msk_ready, "R3", int'(rb_ready), 1);
        @(posedge clk);
        @(negedge clk);
        rb_valid = 1'b0; exp_valid = 1'b0; msk_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int exp_err;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !scrub_req && err_count == 0 && !rb_ready && !exp_ready && !msk_ready,
            "R1", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R4, R5, R7
        pulse_start(NVEC);
        chk(busy && !done, "R6", int'(busy), 1);
        exp_err = 0;
        for (int i = 0; i < NVEC; i++) begin
            chk(!done, "R7", int'(done), 0);
            feed(VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
            if (VEC[i][0]) exp_err++;
            chk(scrub_req == VEC[i][0], "R2", int'(scrub_req), int'(VEC[i][0]));
            chk(err_count == exp_err, "R5", int'(err_count), exp_err);
        end
        chk(done && !busy, "R7", int'(done), 1);
        @(negedge clk);
        chk(!scrub_req, "R4", int'(scrub_req), 0);
        chk(done && err_count == 3, "R7", int'(err_count), 3);

        // New start clears the count (R6)
        pulse_start(3);
        chk(err_count == 0 && !done, "R6", int'(err_count), 0);

        // Stall: one stream missing, nothing consumed (R3)
        rb_valid = 1'b1; exp_valid = 1'b1; msk_valid = 1'b0;
        rb_data = 8'hFF; exp_data = 8'h00; msk_data = 8'hFF;
        repeat (3) begin
            #1;
            chk(!rb_ready && !exp_ready && !msk_ready, "R3", int'(rb_ready), 0);
            @(negedge clk);
        end
        rb_valid = 1'b0; exp_valid = 1'b0;
        chk(err_count == 0 && !scrub_req && busy, "R3", int'(err_count), 0);

        // One bad byte, then a start in mid-run is ignored (R6)
        feed(8'hFF, 8'h00, 8'hFF);
        chk(err_count == 1 && scrub_req, "R4", int'(err_count), 1);
        pulse_start(1);
        chk(err_count == 1 && busy && !done, "R6", int'(err_count), 1);
        feed(8'h11, 8'h11, 8'hFF);
        chk(!done, "R6", int'(done), 0);
        feed(8'h11, 8'h11, 8'hFF);
        chk(done && err_count == 1, "R7", int'(done), 1);

        // Saturation: 20 bad bytes (R5), run not aborted (R7)
        pulse_start(20);
        for (int i = 0; i < 20; i++) begin
            feed(8'h0F, 8'hF0, 8'hFF);
            chk(scrub_req, "R4", int'(scrub_req), 1);
            chk(err_count == ((i + 1 > 15) ? 15 : i + 1), "R5", int'(err_count),
                (i + 1 > 15) ? 15 : i + 1);
        end
        chk(done, "R7", int'(done), 1);

        // Zero length (R8)
        pulse_start(0);
        rb_valid = 1'b1; exp_valid = 1'b1; msk_valid = 1'b1;
        #1;
        chk(done && !busy && !rb_ready && err_count == 0, "R8", int'(done), 1);
        rb_valid = 1'b0; exp_valid = 1'b0; msk_valid = 1'b0;
        @(negedge clk);
        chk(done && !scrub_req, "R8", int'(scrub_req), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule